// File: doc/BRIEF.md
# Minimal Register-Mapped Serial Port

This block is a serial port that software reaches through two word registers on a small synchronous bus. The data word is shared by both directions: a write hands its low byte to the transmitter, and a read returns the byte most recently received. The second word is a clock divisor that sets the bit rate. The block has no status flags and no queue. Software learns that a character has arrived, or that one has left the wire, from two separate one-cycle interrupt pulses.

Characters use 8N1 framing: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The line idles high. A shared tick generator produces one oversampling tick every max(divisor,1) clocks, and sixteen ticks make one bit. The receiver samples at mid-bit. A received character is kept only if its start bit is still low at mid-bit and its stop bit reads high.

The transmitter has the states TX_IDLE, TX_START, TX_DATA and TX_STOP. A data write moves it from TX_IDLE to TX_START. At the end of a bit it moves from TX_START to TX_DATA, and after the eighth data bit from TX_DATA to TX_STOP. When the stop bit ends it moves from TX_STOP to TX_IDLE and pulses the transmit interrupt. The receiver has the states RX_IDLE, RX_START, RX_DATA and RX_STOP. A low line on a tick moves it from RX_IDLE to RX_START. At mid-bit it moves from RX_START to RX_DATA, or back to RX_IDLE if the line is high (a false start). After the eighth sample it moves from RX_DATA to RX_STOP. At the stop-bit sample it moves from RX_STOP to RX_IDLE, storing the byte and pulsing the receive interrupt if the line is high.

Top module: `lean_uart`

## Requirements
- R1: After reset, both registers read 0, txd_o is high, and rx_irq and tx_irq are low.
- R2: The divisor register at byte offset 0x4 holds all 32 written bits. Reads return them until the register is rewritten or reset.
- R3: The register index is bus_addr shifted right by two. Indexes other than 0 (data) and 1 (divisor), for example byte offsets 0x8 and 0xC, read as 0, and writes to them change no register and start no character.
- R4: A write to offset 0x0 sends bits [7:0] as one 8N1 character on txd_o: start bit 0, data bits LSB first, stop bit 1. Each bit lasts 16 × divisor clocks, and the line idles high.
- R5: tx_irq pulses high for exactly one cycle after each transmitted stop bit ends. It does not pulse before the stop bit ends, and it pulses once per character.
- R6: A data write while a character is being sent is ignored. No second character follows, and no extra tx_irq pulse occurs.
- R7: Writing offset 0x0 never changes the value read back from it, and bits [31:8] of the write are ignored.
- R8: When a character with a high stop bit is received, its byte reads back at offset 0x0 (bits [31:8] zero) in the same cycle as a one-cycle rx_irq pulse.
- R9: A low pulse on rxd_i that is high again at mid-bit (8 ticks after detection) is a false start. It produces no rx_irq and leaves the data register unchanged.
- R10: A character whose stop bit reads low is discarded. It produces no rx_irq and leaves the data register unchanged.
- R11: A divisor of 0 acts as a divisor of 1, giving a bit period of 16 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Byte address; bits [ADDR_W-1:2] select the register |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from bus_addr |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| rx_irq | output | 1 | One-cycle pulse when a byte has been received |
| tx_irq | output | 1 | One-cycle pulse when a stop bit has been sent |

## Verification
Two functions can meet in the same cycle: a received character is committed into the data register while software is writing that same register to transmit. The bench starts a transmission and a reception together. It then keeps the data-register write strobe asserted across the whole window in which the received stop bit is sampled, so that one write lands exactly on the commit edge. The bench judges the collision by three things: rx_irq must come with the received byte on the read port and not the written value, the repeated writes must add no character, and they must add no tx_irq pulse while the first character is still going out.

// File: rtl/lean_uart_pkg.sv
package lean_uart_pkg;
    localparam int OVS    = 16;
    localparam int OVS_W  = $clog2(OVS);
    localparam int HALF   = OVS / 2;
    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/lean_uart_tick.sv
module lean_uart_tick #(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    // a divisor of zero behaves as one (R11)
    always_comb limit = (divisor == '0) ? '0 : divisor - DIV_W'(1);

    assign tick = (cnt >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/lean_uart_tx.sv
module lean_uart_tx
    import lean_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [BYTE_W-1:0] din,
    output logic              txd,
    output logic              done_pulse
);
    tx_state_e         state, state_nx;
    logic [OVS_W-1:0]  cnt;
    logic [BIT_W-1:0]  bitn;
    logic [BYTE_W-1:0] shreg;
    logic              bit_end;

    assign bit_end = tick && (cnt == OVS_W'(OVS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE:  if (start) state_nx = TX_START;
            TX_START: if (bit_end) state_nx = TX_DATA;
            TX_DATA:  if (bit_end && bitn == BIT_W'(BYTE_W - 1)) state_nx = TX_STOP;
            TX_STOP:  if (bit_end) state_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            bitn       <= '0;
            shreg      <= '0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= (state == TX_STOP) && bit_end;
            if (state == TX_IDLE) begin
                cnt  <= '0;
                bitn <= '0;
                if (start) shreg <= din;
            end else if (tick) begin
                cnt <= bit_end ? '0 : cnt + OVS_W'(1);
                if (state == TX_DATA && bit_end) begin
                    shreg <= shreg >> 1;
                    bitn  <= bitn + BIT_W'(1);
                end
            end
        end
    end

    always_comb begin
        unique case (state)
            TX_IDLE:  txd = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            TX_STOP:  txd = 1'b1;
        endcase
    end

    // R5: the pulse follows the end of the stop bit and lasts one cycle
    a_r5_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> $past(state) == TX_STOP);
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);
    // R6: a start request while the start bit is going out leaves the byte alone
    a_r6_busy_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_START && start) |=> $stable(shreg));
endmodule

// File: rtl/lean_uart_rx.sv
module lean_uart_rx
    import lean_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd_raw,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_done
);
    rx_state_e         state, state_nx;
    logic [OVS_W-1:0]  cnt;
    logic [BIT_W-1:0]  bitn;
    logic [BYTE_W-1:0] shreg;
    logic              rxd_m, rxd_s;
    logic              mid, bit_end;

    assign mid     = tick && (cnt == OVS_W'(HALF - 1));
    assign bit_end = tick && (cnt == OVS_W'(OVS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxd_m <= 1'b1;
            rxd_s <= 1'b1;
        end else begin
            rxd_m <= rxd_raw;
            rxd_s <= rxd_m;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:  if (tick && !rxd_s) state_nx = RX_START;
            RX_START: if (mid) state_nx = rxd_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_end && bitn == BIT_W'(BYTE_W - 1)) state_nx = RX_STOP;
            RX_STOP:  if (bit_end) state_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
        end else begin
            unique case (state)
                RX_IDLE: begin
                    cnt  <= '0;
                    bitn <= '0;
                end
                RX_START: if (tick) cnt <= mid ? '0 : cnt + OVS_W'(1);
                RX_DATA: if (tick) begin
                    cnt <= bit_end ? '0 : cnt + OVS_W'(1);
                    if (bit_end) begin
                        shreg <= {rxd_s, shreg[BYTE_W-1:1]};
                        bitn  <= bitn + BIT_W'(1);
                    end
                end
                RX_STOP: if (tick) cnt <= cnt + OVS_W'(1);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_byte <= '0;
            rx_done <= 1'b0;
        end else begin
            rx_done <= (state == RX_STOP) && bit_end && rxd_s;
            if ((state == RX_STOP) && bit_end && rxd_s) rx_byte <= shreg;
        end
    end

    // R8: one-cycle completion pulse
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);
    // R10: a byte is accepted only with a high stop sample
    a_r10_stop_was_high: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> $past(rxd_s));
    // R9: a high line at mid start bit returns to idle
    a_r9_false_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && mid && rxd_s) |=> state == RX_IDLE);
    // R7: the stored byte changes only together with a completion pulse
    a_r7_byte_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_byte) |-> rx_done);
endmodule

// File: rtl/lean_uart.sv
module lean_uart
    import lean_uart_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int DIV_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rxd_i,
    output logic              txd_o,
    output logic              rx_irq,
    output logic              tx_irq
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  idx;
    logic              sel_data, sel_div;
    logic [DIV_W-1:0]  div_q;
    logic              tick;
    logic [BYTE_W-1:0] rx_byte;

    assign idx      = bus_addr[ADDR_W-1:2];
    assign sel_data = (idx == IDX_W'(0));
    assign sel_div  = (idx == IDX_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 div_q <= '0;
        else if (bus_we && sel_div) div_q <= bus_wdata[DIV_W-1:0];
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_data)     bus_rdata = DATA_W'(rx_byte);
        else if (sel_div) bus_rdata = DATA_W'(div_q);
    end

    lean_uart_tick #(.DIV_W(DIV_W)) tick_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (div_q),
        .tick    (tick)
    );

    lean_uart_tx tx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .start      (bus_we && sel_data),
        .din        (bus_wdata[BYTE_W-1:0]),
        .txd        (txd_o),
        .done_pulse (tx_irq)
    );

    lean_uart_rx rx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .rxd_raw (rxd_i),
        .rx_byte (rx_byte),
        .rx_done (rx_irq)
    );

    // R3: writes outside the map leave the divisor untouched
    a_r3_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !sel_data && !sel_div) |=> $stable(div_q));
    // R2: a divisor write is read back on the next cycle
    a_r2_div_written: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel_div) |=> div_q == $past(bus_wdata[DIV_W-1:0]));
endmodule

// File: tb/lean_uart_tb_top.sv
`timescale 1ns/1ps
module lean_uart_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rxd = 1'b1;
    logic        txd, rx_irq, tx_irq;

    int checks = 0;
    int errors = 0;
    int bit_clks = 16;
    int tx_irq_cnt = 0;
    int rx_irq_cnt = 0;
    int exp_tx = 0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];

    always #2.5 clk = ~clk;

    lean_uart dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd_i(rxd),
        .txd_o(txd), .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 chk(tag, bus_rdata, exp);
        bus_addr = '0;
    endtask

    task automatic send_tx(input logic [31:0] d);
        tx_q.push_back(d[7:0]);
        exp_tx++;
        wr(4'h0, d);
    endtask

    task automatic drive_rx(input logic [7:0] b, input bit stop_ok);
        if (stop_ok) rx_q.push_back(b);
        @(negedge clk);
        rxd = 1'b0;
        repeat (bit_clks) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (bit_clks) @(negedge clk);
        end
        if (stop_ok) begin
            rxd = 1'b1;
        end else begin
            rxd = 1'b0;
            repeat (bit_clks * 12 / 16) @(negedge clk);
            rxd = 1'b1;
        end
        repeat (bit_clks) @(negedge clk);
    endtask

    task automatic idle_wait();
        repeat (12 * bit_clks) @(negedge clk);
    endtask

    // transmit monitor: decode the line, compare with the scoreboard, time tx_irq
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                logic [7:0] got;
                int c;
                repeat (bit_clks / 2 - 1) @(negedge clk);
                chk("R4 start bit low", {31'd0, txd}, 32'd0);
                for (int i = 0; i < 8; i++) begin
                    repeat (bit_clks) @(negedge clk);
                    got[i] = txd;
                end
                repeat (bit_clks) @(negedge clk);
                chk("R4 stop bit high", {31'd0, txd}, 32'd1);
                if (tx_q.size() == 0) chk("R3/R6 unexpected tx character", {24'd0, got}, 32'hFFFF_FFFF);
                else chk("R4 tx byte", {24'd0, got}, {24'd0, tx_q.pop_front()});
                #1 c = tx_irq_cnt;
                repeat (bit_clks / 2 - bit_clks / 16 - 2) @(negedge clk);
                #1 chk("R5 tx_irq not before stop end", tx_irq_cnt, c);
                repeat (bit_clks / 16 + 4) @(negedge clk);
                #1 chk("R5 tx_irq after stop end", tx_irq_cnt, c + 1);
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && tx_irq === 1'b1) begin
                tx_irq_cnt++;
                @(negedge clk);
                chk("R5 tx_irq one cycle", {31'd0, tx_irq}, 32'd0);
            end
        end
    end

    // receive monitor: pop expected byte on each rx_irq (bus_addr is 0 here)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rx_irq === 1'b1) begin
                rx_irq_cnt++;
                if (rx_q.size() == 0) chk("R9/R10 unexpected rx_irq", 32'd1, 32'd0);
                else chk("R8 rx byte with rx_irq", bus_rdata, {24'd0, rx_q.pop_front()});
                @(negedge clk);
                chk("R8 rx_irq one cycle", {31'd0, rx_irq}, 32'd0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int rc;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 txd idle high", {31'd0, txd}, 32'd1);
        chk("R1 rx_irq low", {31'd0, rx_irq}, 32'd0);
        chk("R1 tx_irq low", {31'd0, tx_irq}, 32'd0);
        rd_chk("R1 data reg zero", 4'h0, 32'd0);
        rd_chk("R1 divisor zero", 4'h4, 32'd0);

        // R11 divisor 0 -> 16 clocks per bit
        bit_clks = 16;
        send_tx(32'h0000_00C3);
        idle_wait();

        // R2 divisor read/write
        wr(4'h4, 32'hDEAD_BEEF);
        rd_chk("R2 divisor full width", 4'h4, 32'hDEAD_BEEF);
        wr(4'h4, 32'd2);
        bit_clks = 32;
        rd_chk("R2 divisor rewritten", 4'h4, 32'd2);

        // R3 unmapped offsets
        wr(4'h8, 32'h0000_0055);
        wr(4'hC, 32'h0000_0007);
        rd_chk("R3 offset 0x8 reads zero", 4'h8, 32'd0);
        rd_chk("R3 offset 0xC reads zero", 4'hC, 32'd0);
        rd_chk("R3 divisor unchanged", 4'h4, 32'd2);
        idle_wait();
        chk("R3 no tx from unmapped write", tx_irq_cnt, exp_tx);

        // R4/R7 upper bits ignored, readback unaffected
        send_tx(32'hFFFF_FF5A);
        idle_wait();
        rd_chk("R7 write does not change readback", 4'h0, 32'd0);
        send_tx(32'h0000_0001);
        idle_wait();
        send_tx(32'h0000_0080);
        idle_wait();

        // R6 write while busy ignored
        send_tx(32'h0000_00A5);
        repeat (40) @(negedge clk);
        wr(4'h0, 32'h0000_003C);
        idle_wait();
        chk("R6 one tx_irq per accepted byte", tx_irq_cnt, exp_tx);

        // R8 reception
        drive_rx(8'h96, 1'b1);
        drive_rx(8'h01, 1'b1);
        rd_chk("R8 last byte held", 4'h0, 32'h0000_0001);

        // R9 false start
        rc = rx_irq_cnt;
        @(negedge clk);
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        rxd = 1'b1;
        idle_wait();
        chk("R9 no rx_irq on glitch", rx_irq_cnt, rc);
        rd_chk("R9 data unchanged", 4'h0, 32'h0000_0001);

        // R10 bad stop bit
        drive_rx(8'h3B, 1'b0);
        idle_wait();
        chk("R10 no rx_irq on bad stop", rx_irq_cnt, rc);
        rd_chk("R10 data unchanged", 4'h0, 32'h0000_0001);

        // R7/R8 collision: data writes held across the receive commit
        fork
            drive_rx(8'h6E, 1'b1);
            begin
                send_tx(32'h0000_0011);
                repeat (9 * bit_clks - 2) @(negedge clk);
                bus_addr = 4'h0; bus_wdata = 32'h0000_0077; bus_we = 1'b1;
                repeat (bit_clks * 8 / 10) @(negedge clk);
                bus_we = 1'b0;
            end
        join
        idle_wait();
        rd_chk("R7 received byte wins over write", 4'h0, 32'h0000_006E);
        chk("R6 no tx_irq from writes while busy", tx_irq_cnt, exp_tx);
        chk("R4 all tx bytes seen", tx_q.size(), 32'd0);
        chk("R8 all rx bytes seen", rx_q.size(), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule